// File: doc/BRIEF.md
# Code Density Linearity Analyzer

This block measures the linearity of a time-to-digital converter with the code density method. Start/stop pairs with random timing produce output codes that are spread evenly over the converter's range. The block counts how often each code occurs, with one counter per code. Once a chosen number of samples has been accepted, it turns the histogram into per-bin differential nonlinearity and into integral nonlinearity, which is the running sum of the differential figure. Both are given in signed fixed point, where 256 equals one LSB.

A run begins with a start command while the block is idle. The block first zeroes every bin, spending one cycle per bin. It then accepts valid codes until the sample target is met. After that it scans the bins once, one per cycle, and stores the differential and integral value of each bin. It also tracks the largest magnitude of each figure. A one-cycle done strobe closes the run. Afterwards the per-bin count, differential and integral values can be read through an address port. A bin counter that hits its ceiling raises a flag, which marks the results of that run as invalid.

Top module: `cdl_analyzer`

## Requirements
- R1: A start pulse while idle clears all bins in NBINS cycles, during which valid codes are not counted. It also clears the saturation flag and both maxima, and raises busy.
- R2: Each valid code accepted during collection adds exactly one to its own bin. This holds when the same code arrives on consecutive cycles.
- R3: Collection ends once the number of accepted samples equals the nonzero target. Codes presented after that point, including codes presented while idle, change no bin.
- R4: A start pulse while busy has no effect on the run in progress.
- R5: The differential value of bin k is floor(count_k × NBINS × 256 / target) − 256, as a signed two's-complement number in which 256 means one LSB.
- R6: The integral value of bin k is the sum of the differential values of bins 0 through k.
- R7: dnl_max_abs and inl_max_abs equal the largest absolute differential and integral values over all bins.
- R8: A bin counter stops at 2^CNT_W−1 instead of wrapping. The sat output then goes high and stays high until the next accepted start.
- R9: done is high for exactly one cycle after the last bin has been evaluated, and busy falls in that same cycle.
- R10: While idle, rd_count, rd_dnl and rd_inl show the bin selected by rd_addr one clock after rd_addr is applied.
- R11: After reset, busy, done, sat, dnl_max_abs and inl_max_abs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (acted on only while idle) |
| code_valid | input | 1 | Strobe marking a valid code |
| code | input | CODE_W | Converter output code |
| target | input | SAMP_W | Number of samples to accept, nonzero |
| rd_addr | input | CODE_W | Bin selected for readout |
| rd_count | output | CNT_W | Histogram count of the selected bin |
| rd_dnl | output | CODE_W+FRAC+2 | Differential value of the selected bin, signed |
| rd_inl | output | CODE_W+FRAC+2 | Integral value of the selected bin, signed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| sat | output | 1 | A bin counter saturated during this run |
| dnl_max_abs | output | CODE_W+FRAC+2 | Largest differential magnitude |
| inl_max_abs | output | CODE_W+FRAC+2 | Largest integral magnitude |

## Verification
The assertions assume that the target is nonzero when a start is accepted and that it does not change during a run. The bench keeps to this by setting the target together with the start pulse and holding it until done. Codes arrive as uniform and skewed random streams with random gaps, and as back-to-back runs of a single code. These runs exercise the read-after-write path of the histogram. Extra codes and a second start are sent while the block is busy, and more codes are sent after done, to show that they have no effect.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_COLLECT,
    ST_SCAN,
    ST_FINISH
  } cdl_state_e;
endpackage

// File: rtl/cdl_ram.sv
module cdl_ram #(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cdl_bin_eval.sv
module cdl_bin_eval #(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 16,
  parameter int SAMP_W = 20,
  parameter int FRAC   = 8,
  localparam int DW  = CODE_W + FRAC + 2,
  localparam int QW  = CNT_W + CODE_W + FRAC,
  localparam int DVW = (QW > SAMP_W) ? QW : SAMP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 in_valid,
  input  logic [CNT_W-1:0]     in_count,
  input  logic [SAMP_W-1:0]    total,
  output logic signed [DW-1:0] dnl_o,
  output logic signed [DW-1:0] inl_o,
  output logic [DW-1:0]        dnl_max,
  output logic [DW-1:0]        inl_max
);
  localparam logic signed [DW-1:0] ONE = DW'(1 << FRAC);

  logic [DVW-1:0]        num, quot;
  logic signed [DW-1:0]  acc;
  logic [DW-1:0]         dnl_mag, inl_mag;

  function automatic logic [DW-1:0] mag(input logic signed [DW-1:0] v);
    return v[DW-1] ? DW'(-v) : DW'(v);
  endfunction

  always_comb begin
    num     = DVW'(in_count) << (CODE_W + FRAC);
    quot    = num / DVW'(total);
    dnl_o   = $signed(quot[DW-1:0]) - ONE;
    inl_o   = acc + dnl_o;
    dnl_mag = mag(dnl_o);
    inl_mag = mag(inl_o);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc     <= '0;
      dnl_max <= '0;
      inl_max <= '0;
    end else if (in_valid) begin
      acc <= inl_o;
      if (dnl_mag > dnl_max) dnl_max <= dnl_mag;
      if (inl_mag > inl_max) inl_max <= inl_mag;
    end
  end

  // R7
  max_mono_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (dnl_max >= $past(dnl_max)) && (inl_max >= $past(inl_max)));
endmodule

// File: rtl/cdl_analyzer.sv
module cdl_analyzer
  import cdl_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CNT_W  = 16,
  parameter int SAMP_W = 20,
  parameter int FRAC   = 8,
  localparam int DW    = CODE_W + FRAC + 2,
  localparam int NBINS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code,
  input  logic [SAMP_W-1:0] target,
  input  logic [CODE_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_count,
  output logic [DW-1:0]     rd_dnl,
  output logic [DW-1:0]     rd_inl,
  output logic              busy,
  output logic              done,
  output logic              sat,
  output logic [DW-1:0]     dnl_max_abs,
  output logic [DW-1:0]     inl_max_abs
);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(NBINS - 1);

  cdl_state_e          state;
  logic [CODE_W-1:0]   idx, a1, a2, lw_a, p_idx;
  logic                v1, v2, lw_v, p_valid, take;
  logic [SAMP_W-1:0]   accepted;
  logic [CNT_W-1:0]    lw_d, h_q, base, inc_val;
  logic                h_we, base_full;
  logic [CODE_W-1:0]   h_waddr, h_raddr;
  logic [CNT_W-1:0]    h_wdata;
  logic signed [DW-1:0] dnl_w, inl_w;

  assign take = (state == ST_COLLECT) && code_valid && (accepted != target);
  assign busy = (state != ST_IDLE);

  // read-modify-write with one level of forwarding for back-to-back codes
  always_comb begin
    base      = (lw_v && lw_a == a2) ? lw_d : h_q;
    base_full = &base;
    inc_val   = base_full ? base : base + 1'b1;
    if (state == ST_CLEAR) begin
      h_we = 1'b1; h_waddr = idx; h_wdata = '0;
    end else begin
      h_we = v2;   h_waddr = a2;  h_wdata = inc_val;
    end
    case (state)
      ST_SCAN:    h_raddr = idx;
      ST_COLLECT: h_raddr = a1;
      default:    h_raddr = rd_addr;
    endcase
  end

  cdl_ram #(.AW(CODE_W), .DW(CNT_W)) u_hist (
    .clk(clk), .we(h_we), .waddr(h_waddr), .wdata(h_wdata),
    .raddr(h_raddr), .rdata(h_q));

  cdl_bin_eval #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SAMP_W(SAMP_W), .FRAC(FRAC)) u_eval (
    .clk(clk), .rst(rst), .clr(state == ST_IDLE && start),
    .in_valid(p_valid), .in_count(h_q), .total(target),
    .dnl_o(dnl_w), .inl_o(inl_w), .dnl_max(dnl_max_abs), .inl_max(inl_max_abs));

  cdl_ram #(.AW(CODE_W), .DW(DW)) u_dnl (
    .clk(clk), .we(p_valid), .waddr(p_idx), .wdata(dnl_w),
    .raddr(rd_addr), .rdata(rd_dnl));

  cdl_ram #(.AW(CODE_W), .DW(DW)) u_inl (
    .clk(clk), .we(p_valid), .waddr(p_idx), .wdata(inl_w),
    .raddr(rd_addr), .rdata(rd_inl));

  assign rd_count = h_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; idx <= '0; accepted <= '0;
      v1 <= 1'b0; v2 <= 1'b0; lw_v <= 1'b0; p_valid <= 1'b0;
      a1 <= '0; a2 <= '0; lw_a <= '0; lw_d <= '0; p_idx <= '0;
      done <= 1'b0; sat <= 1'b0;
    end else begin
      v1 <= take;   a1 <= code;
      v2 <= v1;     a2 <= a1;
      lw_v <= v2;   lw_a <= a2;  lw_d <= inc_val;
      p_valid <= (state == ST_SCAN);
      p_idx   <= idx;
      done    <= (state == ST_FINISH);
      if (v2 && base_full) sat <= 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_CLEAR; idx <= '0; accepted <= '0; sat <= 1'b0;
        end
        ST_CLEAR: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (take) accepted <= accepted + 1'b1;
          if (accepted == target && !v1 && !v2) begin
            state <= ST_SCAN; idx <= '0;
          end
        end
        ST_SCAN: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= ST_FINISH;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && sat) |=> sat);
  // R3
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst) busy |-> accepted <= target);
  // R3
  target_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |-> target != '0);
endmodule

// File: tb/cdl_analyzer_test.sv
`timescale 1ns/1ps
module cdl_analyzer_test;
  localparam int CODE_W = 6;
  localparam int CW     = 12;
  localparam int SAMP_W = 20;
  localparam int FRAC   = 8;
  localparam int DW     = CODE_W + FRAC + 2;
  localparam int NB     = 1 << CODE_W;
  localparam int CMAX   = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, code_valid = 1'b0;
  logic [CODE_W-1:0] code = '0, rd_addr = '0;
  logic [SAMP_W-1:0] target = 1;
  logic [CW-1:0] rd_count;
  logic [DW-1:0] rd_dnl, rd_inl, dnl_max_abs, inl_max_abs;
  logic busy, done, sat;

  int checks = 0, fails = 0;
  int hcnt [NB];
  int m_target, m_acc;
  bit m_sat;

  always #2.5 clk = ~clk;

  cdl_analyzer #(.CODE_W(CODE_W), .CNT_W(CW), .SAMP_W(SAMP_W), .FRAC(FRAC)) uut (
    .clk(clk), .rst(rst), .start(start), .code_valid(code_valid), .code(code),
    .target(target), .rd_addr(rd_addr), .rd_count(rd_count), .rd_dnl(rd_dnl),
    .rd_inl(rd_inl), .busy(busy), .done(done), .sat(sat),
    .dnl_max_abs(dnl_max_abs), .inl_max_abs(inl_max_abs));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_dnl(int k);
    return (longint'(hcnt[k]) * NB * (1 << FRAC)) / m_target - (1 << FRAC);
  endfunction

  function automatic longint lab(longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic start_run(int tgt);
    @(negedge clk);
    start = 1'b1; target = SAMP_W'(tgt);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NB; k++) hcnt[k] = 0;
    m_target = tgt; m_acc = 0; m_sat = 0;
    // R1: codes while clearing are not counted
    code_valid = 1'b1; code = CODE_W'(NB - 1);
    repeat (8) @(negedge clk);
    code_valid = 1'b0;
    repeat (NB + 2 - 8) @(negedge clk);
  endtask

  task automatic send(int c);
    code_valid = 1'b1; code = CODE_W'(c);
    if (m_acc < m_target) begin
      m_acc++;
      if (hcnt[c] == CMAX) m_sat = 1;
      else hcnt[c]++;
    end
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk); n++;
    end
    chk({tag, " R9 done seen"}, longint'(done), 1);
    chk({tag, " R9 busy low with done"}, longint'(busy), 0);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, longint'(done), 0);
  endtask

  task automatic check_all(string tag);
    longint inl = 0, dmax = 0, imax = 0, d;
    for (int k = 0; k < NB; k++) begin
      rd_addr = CODE_W'(k);
      @(negedge clk);
      d = exp_dnl(k);
      inl += d;
      if (lab(d) > dmax) dmax = lab(d);
      if (lab(inl) > imax) imax = lab(inl);
      chk($sformatf("%s R2 R10 count bin %0d", tag, k), longint'(rd_count), hcnt[k]);
      chk($sformatf("%s R5 dnl bin %0d", tag, k), longint'($signed(rd_dnl)), d);
      chk($sformatf("%s R6 inl bin %0d", tag, k), longint'($signed(rd_inl)), inl);
    end
    chk({tag, " R7 dnl max"}, longint'(dnl_max_abs), dmax);
    chk({tag, " R7 inl max"}, longint'(inl_max_abs), imax);
    chk({tag, " R8 sat flag"}, longint'(sat), longint'(m_sat));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5C));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", longint'(busy), 0);
    chk("R11 done", longint'(done), 0);
    chk("R11 sat", longint'(sat), 0);
    chk("R11 dnl max", longint'(dnl_max_abs), 0);
    chk("R11 inl max", longint'(inl_max_abs), 0);

    // uniform random codes with gaps, second start mid-run (R4), extra codes (R3)
    start_run(2048);
    chk("R1 busy after start", longint'(busy), 1);
    while (m_acc < m_target) begin
      if (m_acc == 500) begin start = 1'b1; target = SAMP_W'(2048); end
      send(int'($urandom % NB));
      start = 1'b0;
      if ($urandom % 3 == 0) repeat ($urandom % 3) @(negedge clk);
    end
    for (int j = 0; j < 20; j++) send(int'($urandom % NB));
    wait_done("uniform");
    check_all("uniform R4");

    // skewed distribution, back-to-back
    start_run(3000);
    while (m_acc < m_target) begin
      if ($urandom % 4 == 0) send(int'($urandom % 8));
      else send(int'($urandom % NB));
    end
    wait_done("skewed");
    check_all("skewed");

    // single code repeated every cycle: forwarding path
    start_run(300);
    while (m_acc < m_target) send(17);
    wait_done("single");
    check_all("single");

    // saturation
    start_run(4200);
    while (m_acc < m_target) send(9);
    wait_done("saturate");
    check_all("saturate R8");

    // fresh run clears saturation and bins
    start_run(640);
    chk("R1 R8 sat cleared by start", longint'(sat), 0);
    while (m_acc < m_target) begin
      send(int'($urandom % NB));
      if ($urandom % 2 == 0) @(negedge clk);
    end
    wait_done("fresh");
    check_all("fresh R1");

    // codes while idle change nothing
    for (int j = 0; j < 30; j++) send(0);
    check_all("idle R3");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule